// File: doc/BRIEF.md
# Non-Retriggerable Clocked One-Shot

This block is a synchronous monostable pulse generator. It produces one high pulse on `q`, and its complement on `q_n`, each time a qualified trigger arrives. The pulse lasts a number of clock cycles taken from the `pulse_len` input at the moment the trigger is accepted. Three asynchronous control inputs can start a pulse: an active-low trigger, an active-high trigger, and an active-low clear. Each input passes through its own synchronizer. A trigger counts only on an edge of one input while the other two sit at their enabling levels.

A running pulse cannot be extended or restarted. A falling clear cuts the pulse short and starts a fixed recovery interval. No trigger is accepted during that interval. A held-low clear blocks every trigger. The state machine has three states. `ST_IDLE` waits for a trigger. `ST_PULSE` drives `q` high while the width counter runs down. `ST_RECOVER` holds the outputs idle while the recovery counter runs down. The transitions are:

- **idle→pulse**: a qualified trigger.
- **pulse→idle**: the width counter reaches zero.
- **pulse→recover** and **idle→recover**: clear falls.
- **recover→recover**: clear falls again, which restarts the count.
- **recover→idle**: the recovery count expires.

Top module: `pulse_oneshot`

## Requirements
- R1: After reset and while idle, `q` is 0 and `q_n` is 1.
- R2: A falling edge on `trig_fall_n` while `trig_rise` and `clr_n` are high starts a pulse. `q` is high from the third rising clock edge after the input change, whatever the width.
- R3: A rising edge on `trig_rise` while `trig_fall_n` is low and `clr_n` is high starts a pulse with the same latency.
- R4: A rising edge on `clr_n` while `trig_fall_n` is low and `trig_rise` is high starts a pulse with the same latency, provided the block is idle.
- R5: An edge on `trig_fall_n` or `trig_rise` while another input is at its disabling level starts no pulse.
- R6: A pulse lasts exactly `pulse_len` clock cycles. A `pulse_len` of 0 gives a pulse of 1 cycle.
- R7: Trigger edges that arrive during a pulse are ignored, and the pulse length is not extended.
- R8: A falling edge on `clr_n` ends a running pulse: `q` is low from the third rising clock edge after the change.
- R9: While `clr_n` is held low, trigger edges produce no pulse and the outputs stay idle.
- R10: For `RECOVER_CYC` cycles after a falling clear is detected, all triggers are ignored. A trigger after the interval is accepted.
- R11: `q_n` is always the complement of `q`.
- R12: `pulse_len` is sampled only when a trigger is accepted. Changes during a pulse have no effect on its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_fall_n | input | 1 | Trigger that fires on its falling edge (asynchronous) |
| trig_rise | input | 1 | Trigger that fires on its rising edge (asynchronous) |
| clr_n | input | 1 | Active-low clear; its rising edge is also a trigger |
| pulse_len | input | WIDTH_W (16) | Pulse width in clock cycles, sampled on acceptance |
| q | output | 1 | Pulse output, high during a pulse |
| q_n | output | 1 | Complement of `q` |

## Verification
The trigger paths are tried one at a time, each with its enabling levels and with one companion held at its disabling level. This separates correct qualification from mere edge detection. Widths of 0, 1, small and larger values show whether the counter loads, clamps and ends in the right cycle. Edges injected mid-pulse, width changes mid-pulse, a clear mid-pulse, a held-low clear and a trigger inside the recovery window each single out one of the suppression rules. A long random run, compared against a cycle model built from the requirements, covers simultaneous edges and triggers at the recovery boundary.

// File: rtl/osh_pkg.sv
package osh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PULSE   = 2'd1,
        ST_RECOVER = 2'd2
    } osh_state_e;

    // input lane indices inside the synchronizer vector
    localparam int LANE_A   = 0;
    localparam int LANE_B   = 1;
    localparam int LANE_CLR = 2;
    localparam int LANES    = 3;

endpackage

// File: rtl/osh_sync.sv
module osh_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prev
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_lane
            logic [STAGES-1:0] shreg;
            logic              last;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shreg <= {STAGES{RST_VAL[gi]}};
                    last  <= RST_VAL[gi];
                end else begin
                    shreg <= {shreg[STAGES-2:0], din[gi]};
                    last  <= shreg[STAGES-1];
                end
            end

            assign lvl[gi]  = shreg[STAGES-1];
            assign prev[gi] = last;
        end
    endgenerate

endmodule

// File: rtl/osh_qual.sv
module osh_qual (
    input  logic a_lvl,
    input  logic a_prev,
    input  logic b_lvl,
    input  logic b_prev,
    input  logic c_lvl,
    input  logic c_prev,
    output logic fire
);

    logic a_fall, b_rise, c_rise;
    logic hit_a, hit_b, hit_c;

    always_comb begin
        a_fall = a_prev & ~a_lvl;
        b_rise = b_lvl & ~b_prev;
        c_rise = c_lvl & ~c_prev;
        // each edge is gated by the enabling levels of the other two inputs
        hit_a  = a_fall & b_lvl  & c_lvl;
        hit_b  = b_rise & ~a_lvl & c_lvl;
        hit_c  = c_rise & ~a_lvl & b_lvl;
        fire   = hit_a | hit_b | hit_c;
    end

endmodule

// File: rtl/osh_timer.sv
module osh_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/pulse_oneshot.sv
module pulse_oneshot
    import osh_pkg::*;
#(
    parameter int WIDTH_W     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int RECOVER_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_fall_n,
    input  logic               trig_rise,
    input  logic               clr_n,
    input  logic [WIDTH_W-1:0] pulse_len,
    output logic               q,
    output logic               q_n
);

    localparam int REC_W = $clog2(RECOVER_CYC + 1);
    localparam int CNT_W = (WIDTH_W > REC_W) ? WIDTH_W : REC_W;
    localparam logic [LANES-1:0] SYNC_RST = 3'b101; // clr high, B low, A high
    localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(RECOVER_CYC - 1);

    osh_state_e state, nxt;

    logic [LANES-1:0] s_lvl, s_prev;
    logic             fire;
    logic             clr_lvl, clr_fall;
    logic             cnt_zero, cnt_load;
    logic [CNT_W-1:0] cnt_val, width_m1;

    osh_sync #(
        .N      (LANES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({clr_n, trig_rise, trig_fall_n}),
        .lvl  (s_lvl),
        .prev (s_prev)
    );

    osh_qual u_qual (
        .a_lvl (s_lvl[LANE_A]),
        .a_prev(s_prev[LANE_A]),
        .b_lvl (s_lvl[LANE_B]),
        .b_prev(s_prev[LANE_B]),
        .c_lvl (s_lvl[LANE_CLR]),
        .c_prev(s_prev[LANE_CLR]),
        .fire  (fire)
    );

    assign clr_lvl  = s_lvl[LANE_CLR];
    assign clr_fall = s_prev[LANE_CLR] & ~s_lvl[LANE_CLR];
    assign width_m1 = (pulse_len == '0) ? '0 : CNT_W'(pulse_len - 1'b1);

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (clr_fall)  nxt = ST_RECOVER;
                else if (fire) nxt = ST_PULSE;
            end
            ST_PULSE: begin
                if (clr_fall)      nxt = ST_RECOVER;
                else if (cnt_zero) nxt = ST_IDLE;
            end
            ST_RECOVER: begin
                if (clr_fall)      nxt = ST_RECOVER;
                else if (cnt_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign cnt_load = clr_fall | ((state == ST_IDLE) & fire);
    assign cnt_val  = clr_fall ? REC_LOAD : width_m1;

    osh_timer #(
        .CW(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .zero    (cnt_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        q   = (state == ST_PULSE);
        q_n = ~q;
    end

endmodule

// File: rtl/osh_checker.sv
module osh_checker
    import osh_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       q,
    input logic       q_n,
    input osh_state_e state,
    input logic       clr_lvl,
    input logic       clr_fall,
    input logic       cnt_zero
);

    p_compl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q_n != q);

    p_clear_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fall |=> !q);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_lvl && state == ST_IDLE) |=> !q);

    p_recover_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER && !cnt_zero) |=> (state == ST_RECOVER && !q));

    p_no_retrig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && !cnt_zero && !clr_fall) |=> q);

    p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> ($past(state) == ST_IDLE));

    p_end_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q) |-> ($past(cnt_zero) || $past(clr_fall)));

endmodule

bind pulse_oneshot osh_checker u_osh_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .q       (q),
    .q_n     (q_n),
    .state   (state),
    .clr_lvl (clr_lvl),
    .clr_fall(clr_fall),
    .cnt_zero(cnt_zero)
);

// File: tb/test_pulse_oneshot.sv
module test_pulse_oneshot;

    localparam int CLK_PERIOD = 10;
    localparam int WW         = 16;
    localparam int REC        = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_n = 1'b1;
    logic          b = 1'b0;
    logic          c_n = 1'b1;
    logic [WW-1:0] plen = 16'd5;
    logic          q, q_n;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_oneshot #(.WIDTH_W(WW), .SYNC_STAGES(2), .RECOVER_CYC(REC)) i_pulse_oneshot (
        .clk(clk), .rst_n(rst_n), .trig_fall_n(a_n), .trig_rise(b),
        .clr_n(c_n), .pulse_len(plen), .q(q), .q_n(q_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // cycle model built from the requirements: 2 sync stages, 1 decision edge
    logic [2:0] m_s1, m_cur, m_prev;
    int         m_mode; // 0 idle, 1 pulse, 2 recover
    int         m_cnt;

    function automatic int load_w(input logic [WW-1:0] w);
        return (w == 0) ? 0 : int'(w) - 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 3'b101; m_cur = 3'b101; m_prev = 3'b101;
            m_mode = 0; m_cnt = 0;
        end else begin
            bit af, br, cr, cf, fire;
            af = m_prev[0] & ~m_cur[0];
            br = m_cur[1] & ~m_prev[1];
            cr = m_cur[2] & ~m_prev[2];
            cf = m_prev[2] & ~m_cur[2];
            fire = (af & m_cur[1] & m_cur[2]) | (br & ~m_cur[0] & m_cur[2]) |
                   (cr & ~m_cur[0] & m_cur[1]);
            if (cf) begin
                m_mode = 2; m_cnt = REC - 1;
            end else if (m_mode == 0) begin
                if (fire) begin m_mode = 1; m_cnt = load_w(plen); end
            end else if (m_cnt == 0) begin
                m_mode = 0;
            end else begin
                m_cnt--;
            end
            m_prev = m_cur;
            m_cur  = m_s1;
            m_s1   = {c_n, b, a_n};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(q == (m_mode == 1), {cur_tag, " model q"}, int'(q), int'(m_mode == 1));
            check(q_n == ~q, "R11 complement", int'(q_n), int'(~q));
        end
    end

    // count high cycles over a window after a trigger drive; check latency 3
    task automatic measure(input string tag, input int exp_len);
        int hi = 0;
        int first = 0;
        for (int i = 1; i <= exp_len + 8; i++) begin
            @(negedge clk);
            if (q) begin
                hi++;
                if (first == 0) first = i;
            end
        end
        check(hi == exp_len, {tag, " length"}, hi, exp_len);
        if (exp_len > 0) check(first == 3, {tag, " latency"}, first, 3);
    endtask

    task automatic settle(input logic av, input logic bv, input logic cv, input int n);
        a_n = av; b = bv; c_n = cv;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        check(q == 1'b0 && q_n == 1'b1, "R1 reset outputs", int'(q), 0);
        rst_n = 1'b1;
        settle(1, 1, 1, 6);
        check(q == 1'b0 && q_n == 1'b1, "R1 idle outputs", int'(q), 0);

        cur_tag = "R2";
        plen = 5; a_n = 0; measure("R2 A fall w5", 5);
        settle(1, 1, 1, 4);
        plen = 40; a_n = 0; measure("R2 A fall w40", 40);

        cur_tag = "R3";
        settle(0, 0, 1, 6);
        plen = 3; b = 1; measure("R3 B rise", 3);

        cur_tag = "R5";
        settle(1, 0, 1, 6);
        a_n = 0; measure("R5 A fall with B low", 0);
        settle(1, 0, 1, 6);
        b = 1; measure("R5 B rise with A high", 0);

        cur_tag = "R6";
        settle(1, 1, 1, 6);
        plen = 0; a_n = 0; measure("R6 width zero", 1);
        settle(1, 1, 1, 4);
        plen = 1; a_n = 0; measure("R6 width one", 1);

        cur_tag = "R7";
        settle(1, 1, 1, 4);
        plen = 10; a_n = 0;
        fork
            measure("R7 no retrigger", 10);
            begin
                repeat (4) @(negedge clk); a_n = 1;
                @(negedge clk); a_n = 0;
                @(negedge clk); b = 0;
                @(negedge clk); b = 1;
            end
        join

        cur_tag = "R12";
        settle(1, 1, 1, 6);
        plen = 6; a_n = 0;
        fork
            measure("R12 width change ignored", 6);
            begin repeat (4) @(negedge clk); plen = 30; end
        join

        cur_tag = "R8";
        settle(1, 1, 1, 6);
        plen = 20; a_n = 0;
        fork
            measure("R8 clear truncates", 6);
            begin repeat (6) @(negedge clk); c_n = 0; end
        join

        cur_tag = "R9";
        settle(1, 1, 0, 14);
        fork
            measure("R9 held clear blocks", 0);
            begin
                @(negedge clk); a_n = 0;
                @(negedge clk); b = 0;
                @(negedge clk); b = 1;
            end
        join
        settle(1, 1, 0, 2);

        cur_tag = "R4";
        settle(1, 0, 0, 4);
        settle(0, 0, 0, 4);
        settle(0, 1, 0, 14);
        plen = 7; c_n = 1; measure("R4 clear rise", 7);

        cur_tag = "R10";
        settle(1, 1, 1, 6);
        c_n = 0; @(negedge clk); c_n = 1; @(negedge clk);
        a_n = 0; measure("R10 trigger in recovery", 0);
        settle(1, 1, 1, 10);
        plen = 4; a_n = 0; measure("R10 trigger after recovery", 4);

        cur_tag = "R7 random";
        settle(1, 1, 1, 6);
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 12)      a_n = ~a_n;
            else if (r < 24) b = ~b;
            else if (r < 26) c_n = 1'b0;
            if (!c_n && ($urandom % 100) < 20) c_n = 1'b1;
            plen = WW'($urandom % 13);
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule